// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Emulator

This block is a synthesizable behavioural model of the serial data side of a delta-sigma converter. It serves as a device-side target when a host controller's read logic is under test. The host drives an active-low chip select and a serial clock. The block answers on a data pin with a separate output enable, so the pin can be modelled as tri-state. All inputs are treated as synchronous to the system clock `clk_i`, and serial-clock edges are found by comparing each input with its value in the previous cycle.

The block runs a repeating cycle of three phases: converting, sleeping and shifting out. While it converts, the data pin reads 1 whenever chip select is low. When the programmable conversion time runs out, the block enters sleep by itself and holds a 32-bit frame in a static shift register. The data pin then reads 0, which the host can use as an end-of-conversion signal. A rising serial clock with chip select low starts the readout. Bits change on falling serial-clock edges. The 32nd falling edge starts the next conversion. Raising chip select during a readout abandons it and starts a conversion at once.

The result comes from a parallel word with a load strobe. That word is held in a pending register and is copied into the frame only when a conversion completes. Holding chip select low permanently gives 2-wire operation.

Top module: `adc_serial_port`

## Requirements
- R1: `sdo_oe_o` is 0 whenever `csn_i` is 1 (pin high-impedance) and 1 whenever `csn_i` is 0.
- R2: Outside a readout, `sdo_o` is 1 while a conversion runs and 0 while asleep with a frame ready.
- R3: A conversion lasts exactly `conv_len_i` clock cycles (a value of 0 acts as 1). Sleep is then entered whatever `csn_i` is doing, and the frame is held until it is read.
- R4: In sleep and in external-clock mode, a readout starts on the first serial-clock rise seen with `csn_i` low. `sdo_o` changes only on serial-clock falls. Frame bit k, counted from 0 at the rise that starts the readout, appears after k falls. The frame order is: bit 0 end-of-conversion (0), bit 1 a dummy 0, bit 2 the sign `result_i[29]`, bits 3..26 `result_i[28:5]` MSB first, and bits 27..31 `result_i[4:0]`.
- R5: The 32nd serial-clock fall of a readout starts a new conversion, and `sdo_o` reads 1 from the next clock cycle.
- R6: If `csn_i` goes high at any point of a readout, the readout is abandoned and a new conversion starts at once. The frame delivered after that conversion carries the pending word.
- R7: A `csn_i` fall with `sclk_i` low selects external-clock mode (`ext_mode_o`=1). A `csn_i` fall with `sclk_i` high clears it, and serial-clock edges are then ignored until a later `csn_i` fall with `sclk_i` low.
- R8: In the first clock cycle after reset release, `ext_mode_o` takes the inverse of `sclk_i`. This allows 2-wire operation with `csn_i` held low, reading frames back to back by polling the end-of-conversion flag.
- R9: A word loaded with `load_i` during a readout does not alter that frame. It is delivered in the frame that follows the next conversion, and without a new load the previous word is delivered again.
- R10: After reset the block is converting, and the pending word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Externally driven serial clock |
| load_i | input | 1 | Load strobe for `result_i` |
| result_i | input | RES_W+SUB_W+1 | Sign, result and sub-LSB bits |
| conv_len_i | input | CNT_W | Conversion time in clock cycles |
| sdo_o | output | 1 | Serial data / end-of-conversion flag |
| sdo_oe_o | output | 1 | Output enable for the data pin |
| ext_mode_o | output | 1 | External serial-clock mode selected |

## Verification
The bench builds the block with the default 24 result bits and 5 sub-LSB bits, so it checks the full 32-bit frame layout. It sets `CNT_W` to 6, which keeps conversions short enough to test the zero-length case, lengths of one cycle and random lengths up to 40 cycles. Many readouts, aborts and reset-time mode selections therefore fit in one short run.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DATA  = 2'd2
  } port_state_e;
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // a length of 0 finishes after one cycle, like a length of 1
  assign done_o = run_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i)           cnt_q <= '0;
    else if (run_i && !done_o)    cnt_q <= cnt_q + 1'b1;
  end

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o && !restart_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         start_i,
  input  logic         shift_i,
  output logic         msb_o,
  output logic         last_o
);
  logic [W-1:0]  shreg_q;
  logic [CW-1:0] bit_q;

  assign msb_o  = shreg_q[W-1];
  assign last_o = (bit_q == CW'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      bit_q   <= '0;
    end else begin
      if (load_i)       shreg_q <= load_val_i;
      else if (shift_i) shreg_q <= {shreg_q[W-2:0], 1'b0};
      if (start_i)      bit_q <= '0;
      else if (shift_i) bit_q <= bit_q + 1'b1;
    end
  end

  // result held static while not loading or shifting
  a_r9_frame_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(shreg_q));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int RES_W = 24,
  parameter int SUB_W = 5,
  parameter int CNT_W = 16,
  localparam int WORD_W  = RES_W + SUB_W + 1,
  localparam int FRAME_W = WORD_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] result_i,
  input  logic [CNT_W-1:0]  conv_len_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              ext_mode_o
);
  port_state_e state_q, state_d;
  logic sclk_q, csn_q, por_q, ext_mode_q;
  logic [WORD_W-1:0] pend_q;
  logic sclk_rise, sclk_fall, csn_fall;
  logic conv_done, frame_start, frame_shift, frame_end, abort, restart;
  logic shf_msb, shf_last;

  assign sclk_rise = sclk_i && !sclk_q;
  assign sclk_fall = !sclk_i && sclk_q;
  assign csn_fall  = !csn_i && csn_q;

  assign frame_start = (state_q == ST_SLEEP) && sclk_rise && !csn_i && !csn_q && ext_mode_q;
  assign frame_shift = (state_q == ST_DATA) && sclk_fall && !csn_i;
  assign frame_end   = frame_shift && shf_last;
  assign abort       = (state_q == ST_DATA) && csn_i;
  assign restart     = frame_end || abort;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      csn_q      <= 1'b1;
      por_q      <= 1'b0;
      ext_mode_q <= 1'b0;
      pend_q     <= '0;
      state_q    <= ST_CONV;
    end else begin
      sclk_q  <= sclk_i;
      csn_q   <= csn_i;
      por_q   <= 1'b1;
      state_q <= state_d;
      if (!por_q || csn_fall) ext_mode_q <= !sclk_i;
      if (load_i)             pend_q <= result_i;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CONV:  if (conv_done)   state_d = ST_SLEEP;
      ST_SLEEP: if (frame_start) state_d = ST_DATA;
      ST_DATA:  if (restart)     state_d = ST_CONV;
      default:                   state_d = ST_CONV;
    endcase
  end

  conv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (state_q == ST_CONV),
    .len_i     (conv_len_i),
    .done_o    (conv_done)
  );

  // frame: end-of-conversion 0, dummy 0, then the pending word
  frame_shifter #(.W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (conv_done),
    .load_val_i ({2'b00, pend_q}),
    .start_i    (frame_start),
    .shift_i    (frame_shift),
    .msb_o      (shf_msb),
    .last_o     (shf_last)
  );

  assign sdo_o      = (state_q == ST_CONV) ? 1'b1 : shf_msb;
  assign sdo_oe_o   = !csn_i;
  assign ext_mode_o = ext_mode_q;

  a_r2_sleep_flag_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP) |-> !sdo_o);

  a_r4_start_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !sclk_rise) |=> (state_q != ST_DATA));

  a_r5_frame_end_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (state_q == ST_CONV && sdo_o));

  a_r6_abort_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && csn_i) |=> (state_q == ST_CONV));

  a_r7_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_q && !csn_fall) |=> $stable(ext_mode_q));
endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int RES_W = 24;
  localparam int SUB_W = 5;
  localparam int CNT_W = 6;
  localparam int WORD_W = RES_W + SUB_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, load = 1'b0;
  logic [WORD_W-1:0] word = '0;
  logic [CNT_W-1:0]  clen = 6'd30;
  logic sdo, sdo_oe, ext_mode;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  adc_serial_port #(.RES_W(RES_W), .SUB_W(SUB_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .load_i(load),
    .result_i(word), .conv_len_i(clen), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .ext_mode_o(ext_mode)
  );

  function automatic logic [31:0] exp_frame(input logic [WORD_W-1:0] w);
    return {2'b00, w};
  endfunction

  function automatic int exp_len(input logic [CNT_W-1:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_sleep();
    int n = 0;
    while (sdo !== 1'b0 && n < 2000) begin tick(); n++; end
    chk(sdo === 1'b0, "R3 sleep reached", 32'(sdo), 0);
  endtask

  // full readout; optional load of nw before fall number load_at
  task automatic read_frame(output logic [31:0] f, input int load_at, input logic [WORD_W-1:0] nw);
    f = '0;
    for (int i = 0; i < 32; i++) begin
      sclk = 1'b1;
      tick();
      f[31-i] = sdo;
      if (i == load_at) begin
        load = 1'b1; word = nw; tick(); load = 1'b0;
      end else tick();
      sclk = 1'b0;
      tick();
      if (i < 31) tick();
    end
  endtask

  task automatic measure_conv(output int n);
    n = 0;
    while (sdo === 1'b1 && n < 3000) begin n++; tick(); end
  endtask

  task automatic do_reset(input logic cs_lvl, input logic sck_lvl);
    rst_n = 1'b0; csn = cs_lvl; sclk = sck_lvl;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] f;
    logic [WORD_W-1:0] prev, nw;
    int n, k;
    void'($urandom(32'h1f2e3d4c));

    // reset with chip select high
    do_reset(1'b1, 1'b0);
    chk(sdo_oe === 1'b0, "R1 oe low with csn high", 32'(sdo_oe), 0);
    prev = WORD_W'($urandom());
    load = 1'b1; word = prev; csn = 1'b0; tick(); load = 1'b0;
    chk(sdo_oe === 1'b1, "R1 oe high with csn low", 32'(sdo_oe), 1);
    chk(sdo === 1'b1, "R10 converting after reset", 32'(sdo), 1);
    chk(ext_mode === 1'b1, "R7 ext mode with sclk low at csn fall", 32'(ext_mode), 1);
    wait_sleep();
    csn = 1'b1; tick();
    chk(sdo_oe === 1'b0, "R1 hi-z in sleep", 32'(sdo_oe), 0);
    repeat (5) tick();
    csn = 1'b0; tick();
    chk(sdo === 1'b0, "R2 flag low in sleep", 32'(sdo), 0);

    // random readouts with a load during each frame
    for (int it = 0; it < 10; it++) begin
      clen = (it == 0) ? 6'd0 : (it == 1) ? 6'd1 : CNT_W'($urandom_range(2, 40));
      nw = WORD_W'($urandom());
      k = $urandom_range(0, 30);
      read_frame(f, k, nw);
      chk(f === exp_frame(prev), "R4 R9 frame content", f, exp_frame(prev));
      chk(sdo === 1'b1, "R5 conversion after 32nd fall", 32'(sdo), 1);
      measure_conv(n);
      chk(n == exp_len(clen), "R3 conversion length", 32'(n), 32'(exp_len(clen)));
      chk(sdo === 1'b0, "R2 flag low after conversion", 32'(sdo), 0);
      prev = nw;
    end

    // abort after k falls, directed k=0 first
    clen = 6'd12;
    for (int it = 0; it < 4; it++) begin
      k = (it == 0) ? 0 : $urandom_range(1, 31);
      for (int i = 0; i < k; i++) begin
        sclk = 1'b1; tick(); tick();
        sclk = 1'b0; tick(); tick();
      end
      sclk = 1'b1; tick();
      csn = 1'b1; tick();
      sclk = 1'b0; tick();
      chk(sdo_oe === 1'b0, "R1 hi-z during abort", 32'(sdo_oe), 0);
      csn = 1'b0; tick();
      chk(sdo === 1'b1, "R6 abort starts conversion", 32'(sdo), 1);
      wait_sleep();
      read_frame(f, -1, '0);
      chk(f === exp_frame(prev), "R6 frame after abort", f, exp_frame(prev));
      measure_conv(n);
    end

    // csn fall with sclk high: clock edges ignored
    csn = 1'b1; sclk = 1'b1; tick();
    csn = 1'b0; tick();
    chk(ext_mode === 1'b0, "R7 mode cleared by sclk high", 32'(ext_mode), 0);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; tick(); tick();
      sclk = 1'b1; tick(); tick();
    end
    chk(sdo === 1'b0, "R7 no readout in non-ext mode", 32'(sdo), 0);
    csn = 1'b1; sclk = 1'b0; tick();
    csn = 1'b0; tick();
    chk(ext_mode === 1'b1, "R7 mode restored", 32'(ext_mode), 1);
    read_frame(f, -1, '0);
    chk(f === exp_frame(prev), "R7 frame intact", f, exp_frame(prev));
    measure_conv(n);

    // 2-wire with sclk high at reset release
    do_reset(1'b0, 1'b1);
    chk(ext_mode === 1'b0, "R8 mode from sclk high at reset", 32'(ext_mode), 0);
    clen = 6'd8;
    load = 1'b1; word = {1'b1, WORD_W'($urandom()) >> 1} | (WORD_W'(1) << (WORD_W-1)); tick(); load = 1'b0;
    wait_sleep();
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; tick(); tick();
      sclk = 1'b1; tick(); tick();
      chk(sdo === 1'b0, "R8 edges ignored", 32'(sdo), 0);
    end

    // 2-wire with sclk low at reset release
    do_reset(1'b0, 1'b0);
    chk(ext_mode === 1'b1, "R8 mode from sclk low at reset", 32'(ext_mode), 1);
    prev = WORD_W'($urandom());
    load = 1'b1; word = prev; tick(); load = 1'b0;
    wait_sleep();
    for (int it = 0; it < 3; it++) begin
      nw = WORD_W'($urandom());
      read_frame(f, 20, nw);
      chk(f === exp_frame(prev), "R8 back-to-back frame", f, exp_frame(prev));
      measure_conv(n);
      chk(n == 8, "R3 conversion length 2-wire", 32'(n), 8);
      prev = nw;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule